// File: doc/BRIEF.md
# Programmable External Parallel Bus Master

This block carries single read and write transfers from an internal request port out to one device on an external parallel bus, such as a NOR-style flash or a memory-mapped peripheral. Every phase of an access has its own length field. A field holding value n gives n+1 clock cycles. The phases are the idle lead-in before chip enable, the optional address phase on a shared address/data bus, the write or read strobe, and the hold time after the strobe. The read path waits a programmed number of cycles before it looks at the device's ready line. It then captures read data either in the cycle in which ready is seen, or one cycle later when the device signals ready early.

The internal side issues a request with `req_valid` while `req_ready` is high and gets a one-cycle `rsp_done` back. For reads, the captured word comes with that pulse. The configuration inputs are static and are latched when a request is accepted. They select 16- or 32-bit data lanes, multiplexed or separate address, when ready is sampled, and an active level for each strobe. Every bus output comes straight from a flop. The shared bus is split into an output word, an output enable and an input word, so the tri-state buffer sits outside the block.

Top module: `xbus_master`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_done` and `bus_ad_oe` are 0. With all polarity bits at 0, `bus_ce`, `bus_adv`, `bus_oe` and `bus_we` sit at 1 (inactive).
- R2: After the accepting clock edge, all strobes stay inactive for ce_setup+1 cycles. Chip enable becomes active in the following cycle.
- R3: With `cfg_muxed`=1, an address phase of mux_len+1 cycles follows the lead-in. During it chip enable is active, `bus_ad_oe`=1, and `bus_ad_out` carries the address, zero-extended and masked to the active lanes. Address-valid is active for the first min(adv_len+1, mux_len+1) of those cycles.
- R4: With `cfg_muxed`=0 there is no address phase and address-valid never becomes active. The strobe phase starts right after the lead-in. `bus_addr` carries the request address whenever an access is in progress.
- R5: A write keeps write enable active for exactly we_len+1 cycles. The write data drives `bus_ad_out` with `bus_ad_oe`=1 from the first strobe cycle to the end of the hold phase.
- R6: A read keeps output enable active with `bus_ad_oe`=0. Ready is ignored in strobe cycles 0..wait_len (counted from 0). With `cfg_rdy_early`=0, data is captured at the first later edge that sees ready active. With `cfg_rdy_early`=1, it is captured one edge after that. Output enable stays active through cycle max(capture cycle, oe_len). Write and output enable are never active together.
- R7: After write or output enable goes inactive, chip enable stays active for hold_len+1 cycles. Then the block is idle.
- R8: `rsp_done` is a one-cycle pulse. For a read it appears in the cycle after the capture edge, with `rsp_rdata` valid. For a write it appears in the first hold cycle.
- R9: With `cfg_wide`=0, only lanes 15:0 and byte enables 1:0 are used. Upper lanes of `bus_ad_out`, upper bits of `bus_be` and upper bits of `rsp_rdata` are 0. With `cfg_wide`=1, all 32 bits and 4 byte enables are used.
- R10: Each of `cfg_ce_hi`, `cfg_adv_hi`, `cfg_strb_hi` (write and output enable), and `cfg_rdy_hi` makes its line active high when 1 and active low when 0. In idle, the strobes sit at the inactive level of the live configuration.
- R11: Configuration inputs changed after acceptance have no effect on the running access. Its timing, polarity, width and mode all follow the values present at acceptance.
- R12: `req_ready` is 1 only in idle, with all strobes inactive. At least one idle cycle separates the end of one access from the start of the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Device address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done |
| cfg_ce_setup | input | 4 | Lead-in length before chip enable, minus one |
| cfg_adv_len | input | 4 | Address-valid length, minus one |
| cfg_mux_len | input | 4 | Shared-bus address phase length, minus one |
| cfg_we_len | input | 4 | Write strobe length, minus one |
| cfg_oe_len | input | 8 | Minimum read strobe length, minus one |
| cfg_hold_len | input | 4 | Chip enable hold after strobe, minus one |
| cfg_wait_len | input | 8 | Strobe cycles with ready ignored, minus one |
| cfg_wide | input | 1 | 1 = 32-bit data, 0 = 16-bit |
| cfg_muxed | input | 1 | 1 = address shares the data lines |
| cfg_rdy_early | input | 1 | 1 = ready precedes data by one cycle |
| cfg_rdy_hi | input | 1 | Ready active high |
| cfg_adv_hi | input | 1 | Address-valid active high |
| cfg_strb_hi | input | 1 | Write/output enable active high |
| cfg_ce_hi | input | 1 | Chip enable active high |
| bus_ce | output | 1 | Chip enable |
| bus_adv | output | 1 | Address valid |
| bus_oe | output | 1 | Output enable |
| bus_we | output | 1 | Write enable |
| bus_rdy | input | 1 | Device ready |
| bus_addr | output | ADDR_W | Dedicated address lines |
| bus_be | output | DATA_W/8 | Byte enables, active high |
| bus_ad_out | output | DATA_W | Shared address/data bus, outgoing value |
| bus_ad_oe | output | 1 | Drive enable for the shared bus |
| bus_ad_in | input | DATA_W | Shared address/data bus, incoming value |

## Verification
The bench walks a 256-point grid that crosses read and write, separate and shared address, both data widths, all sixteen polarity combinations and both ready modes. Phase lengths and the device's ready delay are stepped through small values. Every pin is compared cycle by cycle against an arithmetic timeline, which separates off-by-one faults in each phase counter from one another. A device model drives garbage on the data lines until data is really valid. The ready delay is set both shorter and longer than the wait count, which shows whether the wait gate and the early-ready offset are honoured. Extreme lengths (all 15s, 255) exercise the counters near saturation. Some accesses invert the whole configuration right after acceptance, which exposes any path that reads live inputs mid-transfer.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  localparam int SHORT_W = 4;
  localparam int LONG_W  = 8;
  localparam int CNT_W   = LONG_W + 1;

  typedef struct packed {
    logic [SHORT_W-1:0] ce_setup;
    logic [SHORT_W-1:0] adv_len;
    logic [SHORT_W-1:0] mux_len;
    logic [SHORT_W-1:0] we_len;
    logic [SHORT_W-1:0] hold_len;
    logic [LONG_W-1:0]  oe_len;
    logic [LONG_W-1:0]  wait_len;
    logic               wide;
    logic               muxed;
    logic               rdy_early;
    logic               rdy_hi;
    logic               adv_hi;
    logic               strb_hi;
    logic               ce_hi;
  } xbus_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ADDR,
    ST_STROBE,
    ST_HOLD
  } xbus_state_e;

  typedef struct packed {
    logic ce;
    logic adv;
    logic we;
    logic oe;
  } xbus_act_t;

endpackage

// File: rtl/xbus_capture.sv
module xbus_capture
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              in_idle,
  input  xbus_cfg_t         cfg_in,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output xbus_cfg_t         cfg_use,
  output logic              write_use,
  output logic [ADDR_W-1:0] addr_use,
  output logic [DATA_W-1:0] wdata_use,
  output logic [BE_W-1:0]   be_use
);

  xbus_cfg_t         cfg_q;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BE_W-1:0]   be_q;

  // Snapshot of the request and configuration taken at the accepting edge
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      cfg_q   <= cfg_in;
      write_q <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  // While idle the live inputs steer the next-state logic; afterwards the snapshot
  assign cfg_use   = in_idle ? cfg_in    : cfg_q;
  assign write_use = in_idle ? req_write : write_q;
  assign addr_use  = in_idle ? req_addr  : addr_q;
  assign wdata_use = in_idle ? req_wdata : wdata_q;
  assign be_use    = in_idle ? req_be    : be_q;

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      req_valid,
  input  xbus_cfg_t cfg,
  input  logic      write,
  input  logic      rdy_pin,
  output logic      req_ready,
  output logic      accept,
  output logic      cap_now,
  output logic      done_nxt,
  output xbus_act_t act_nxt,
  output logic      ad_oe_nxt,
  output logic      addr_phase_nxt,
  output logic      busy_nxt
);

  xbus_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             got_q, got_d, pend_q, pend_d;
  logic             rdy_act, in_read, wait_ok, ok_now, oe_done, last;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready & req_valid;

  assign rdy_act = cfg.rdy_hi ? rdy_pin : ~rdy_pin;
  assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
  assign in_read = (state_q == ST_STROBE) && !write;

  // Ready counts only once strobe cycle index exceeds the wait field
  assign wait_ok = cnt_q > CNT_W'(cfg.wait_len);
  assign ok_now  = in_read && wait_ok && rdy_act && !got_q && !pend_q;
  assign cap_now = in_read && !got_q && (cfg.rdy_early ? pend_q : ok_now);
  assign oe_done = cnt_q >= CNT_W'(cfg.oe_len);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_inc;
    last    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (accept) state_d = ST_SETUP;
      end
      ST_SETUP: begin
        if (cnt_q == CNT_W'(cfg.ce_setup)) begin
          state_d = cfg.muxed ? ST_ADDR : ST_STROBE;
          cnt_d   = '0;
        end
      end
      ST_ADDR: begin
        if (cnt_q == CNT_W'(cfg.mux_len)) begin
          state_d = ST_STROBE;
          cnt_d   = '0;
        end
      end
      ST_STROBE: begin
        last = write ? (cnt_q == CNT_W'(cfg.we_len)) : ((got_q | cap_now) && oe_done);
        if (last) begin
          state_d = ST_HOLD;
          cnt_d   = '0;
        end
      end
      ST_HOLD: begin
        if (cnt_q == CNT_W'(cfg.hold_len)) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  assign pend_d   = (state_q == ST_IDLE) ? 1'b0 : (pend_q | (cfg.rdy_early & ok_now));
  assign got_d    = (state_q == ST_IDLE) ? 1'b0 : (got_q | cap_now);
  assign done_nxt = cap_now | ((state_q == ST_STROBE) && write && last);

  // Pin activity decoded from the next state so registered pins line up with it
  always_comb begin
    act_nxt.ce     = (state_d == ST_ADDR) || (state_d == ST_STROBE) || (state_d == ST_HOLD);
    act_nxt.adv    = (state_d == ST_ADDR) && (cnt_d <= CNT_W'(cfg.adv_len));
    act_nxt.we     = (state_d == ST_STROBE) && write;
    act_nxt.oe     = (state_d == ST_STROBE) && !write;
    ad_oe_nxt      = (state_d == ST_ADDR) ||
                     (((state_d == ST_STROBE) || (state_d == ST_HOLD)) && write);
    addr_phase_nxt = (state_d == ST_ADDR);
    busy_nxt       = (state_d != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      got_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      got_q   <= got_d;
      pend_q  <= pend_d;
    end
  end

endmodule

// File: rtl/xbus_io.sv
module xbus_io
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  xbus_cfg_t         cfg,
  input  xbus_act_t         act_nxt,
  input  logic              ad_oe_nxt,
  input  logic              addr_phase_nxt,
  input  logic              busy_nxt,
  input  logic              done_nxt,
  input  logic              cap_now,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] ad_in,
  output logic              bus_ce,
  output logic              bus_adv,
  output logic              bus_oe,
  output logic              bus_we,
  output xbus_act_t         act_q,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-1:0] addr_pin,
  output logic [BE_W-1:0]   be_pin,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  localparam int HALF    = DATA_W / 2;
  localparam int BE_HALF = BE_W / 2;

  logic [DATA_W-1:0] lane_mask, addr_ext, ad_nxt;
  logic [BE_W-1:0]   be_mask;

  generate
    if (ADDR_W >= DATA_W) begin : g_addr_trunc
      assign addr_ext = addr[DATA_W-1:0];
    end else begin : g_addr_ext
      assign addr_ext = {{(DATA_W-ADDR_W){1'b0}}, addr};
    end
  endgenerate

  assign lane_mask = cfg.wide ? {DATA_W{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
  assign be_mask   = cfg.wide ? {BE_W{1'b1}}   : {{BE_HALF{1'b0}}, {BE_HALF{1'b1}}};
  assign ad_nxt    = ad_oe_nxt ? ((addr_phase_nxt ? addr_ext : wdata) & lane_mask) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ce   <= 1'b1;
      bus_adv  <= 1'b1;
      bus_oe   <= 1'b1;
      bus_we   <= 1'b1;
      act_q    <= '0;
      ad_out   <= '0;
      ad_oe    <= 1'b0;
      addr_pin <= '0;
      be_pin   <= '0;
      rdata    <= '0;
      done     <= 1'b0;
    end else begin
      bus_ce   <= cfg.ce_hi   ? act_nxt.ce  : ~act_nxt.ce;
      bus_adv  <= cfg.adv_hi  ? act_nxt.adv : ~act_nxt.adv;
      bus_oe   <= cfg.strb_hi ? act_nxt.oe  : ~act_nxt.oe;
      bus_we   <= cfg.strb_hi ? act_nxt.we  : ~act_nxt.we;
      act_q    <= act_nxt;
      ad_out   <= ad_nxt;
      ad_oe    <= ad_oe_nxt;
      addr_pin <= busy_nxt ? addr : '0;
      be_pin   <= busy_nxt ? (be & be_mask) : '0;
      done     <= done_nxt;
      if (cap_now) rdata <= ad_in & lane_mask;
    end
  end

endmodule

// File: rtl/xbus_master.sv
module xbus_master
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [BE_W-1:0]    req_be,
  output logic               rsp_done,
  output logic [DATA_W-1:0]  rsp_rdata,
  input  logic [SHORT_W-1:0] cfg_ce_setup,
  input  logic [SHORT_W-1:0] cfg_adv_len,
  input  logic [SHORT_W-1:0] cfg_mux_len,
  input  logic [SHORT_W-1:0] cfg_we_len,
  input  logic [LONG_W-1:0]  cfg_oe_len,
  input  logic [SHORT_W-1:0] cfg_hold_len,
  input  logic [LONG_W-1:0]  cfg_wait_len,
  input  logic               cfg_wide,
  input  logic               cfg_muxed,
  input  logic               cfg_rdy_early,
  input  logic               cfg_rdy_hi,
  input  logic               cfg_adv_hi,
  input  logic               cfg_strb_hi,
  input  logic               cfg_ce_hi,
  output logic               bus_ce,
  output logic               bus_adv,
  output logic               bus_oe,
  output logic               bus_we,
  input  logic               bus_rdy,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [BE_W-1:0]    bus_be,
  output logic [DATA_W-1:0]  bus_ad_out,
  output logic               bus_ad_oe,
  input  logic [DATA_W-1:0]  bus_ad_in
);

  xbus_cfg_t         cfg_in, cfg_use;
  xbus_act_t         act_nxt, act_q;
  logic              accept, cap_now, done_nxt, ad_oe_nxt, addr_phase_nxt, busy_nxt;
  logic              write_use;
  logic [ADDR_W-1:0] addr_use;
  logic [DATA_W-1:0] wdata_use;
  logic [BE_W-1:0]   be_use;

  always_comb begin
    cfg_in.ce_setup  = cfg_ce_setup;
    cfg_in.adv_len   = cfg_adv_len;
    cfg_in.mux_len   = cfg_mux_len;
    cfg_in.we_len    = cfg_we_len;
    cfg_in.hold_len  = cfg_hold_len;
    cfg_in.oe_len    = cfg_oe_len;
    cfg_in.wait_len  = cfg_wait_len;
    cfg_in.wide      = cfg_wide;
    cfg_in.muxed     = cfg_muxed;
    cfg_in.rdy_early = cfg_rdy_early;
    cfg_in.rdy_hi    = cfg_rdy_hi;
    cfg_in.adv_hi    = cfg_adv_hi;
    cfg_in.strb_hi   = cfg_strb_hi;
    cfg_in.ce_hi     = cfg_ce_hi;
  end

  xbus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_capture (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .in_idle   (req_ready),
    .cfg_in    (cfg_in),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .cfg_use   (cfg_use),
    .write_use (write_use),
    .addr_use  (addr_use),
    .wdata_use (wdata_use),
    .be_use    (be_use)
  );

  xbus_seq u_seq (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .cfg            (cfg_use),
    .write          (write_use),
    .rdy_pin        (bus_rdy),
    .req_ready      (req_ready),
    .accept         (accept),
    .cap_now        (cap_now),
    .done_nxt       (done_nxt),
    .act_nxt        (act_nxt),
    .ad_oe_nxt      (ad_oe_nxt),
    .addr_phase_nxt (addr_phase_nxt),
    .busy_nxt       (busy_nxt)
  );

  xbus_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_io (
    .clk            (clk),
    .rst            (rst),
    .cfg            (cfg_use),
    .act_nxt        (act_nxt),
    .ad_oe_nxt      (ad_oe_nxt),
    .addr_phase_nxt (addr_phase_nxt),
    .busy_nxt       (busy_nxt),
    .done_nxt       (done_nxt),
    .cap_now        (cap_now),
    .addr           (addr_use),
    .wdata          (wdata_use),
    .be             (be_use),
    .ad_in          (bus_ad_in),
    .bus_ce         (bus_ce),
    .bus_adv        (bus_adv),
    .bus_oe         (bus_oe),
    .bus_we         (bus_we),
    .act_q          (act_q),
    .ad_out         (bus_ad_out),
    .ad_oe          (bus_ad_oe),
    .addr_pin       (bus_addr),
    .be_pin         (bus_be),
    .rdata          (rsp_rdata),
    .done           (rsp_done)
  );

endmodule

// File: rtl/xbus_master_chk.sv
module xbus_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_done,
  input logic [3:0] act,
  input logic       ad_oe
);
  // act bit order: [3] chip enable, [2] address valid, [1] write enable, [0] output enable

  p_setup_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!act[3] && !req_ready));

  p_adv_inside_ce_r3: assert property (@(posedge clk) disable iff (rst)
    act[2] |-> act[3]);

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(act[1] && act[0]));

  p_read_released_r6: assert property (@(posedge clk) disable iff (rst)
    act[0] |-> !ad_oe);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (act == 4'b0000));

  p_gap_after_ce_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(act[3]) |-> req_ready);

endmodule

bind xbus_master xbus_master_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .act       (act_q),
  .ad_oe     (bus_ad_oe)
);

// File: tb/xbus_master_tb.sv
module xbus_master_tb;
  import xbus_pkg::*;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int HALF   = DATA_W / 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst;
  logic              req_valid, req_ready, req_write, rsp_done;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata, rsp_rdata, bus_ad_out, bus_ad_in;
  logic [BE_W-1:0]   req_be, bus_be;
  logic              bus_ce, bus_adv, bus_oe, bus_we, bus_rdy, bus_ad_oe;
  logic [ADDR_W-1:0] bus_addr;
  xbus_cfg_t         cfg_tb;

  int n_cmp = 0;
  int n_bad = 0;

  xbus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .cfg_ce_setup(cfg_tb.ce_setup), .cfg_adv_len(cfg_tb.adv_len),
    .cfg_mux_len(cfg_tb.mux_len), .cfg_we_len(cfg_tb.we_len),
    .cfg_oe_len(cfg_tb.oe_len), .cfg_hold_len(cfg_tb.hold_len),
    .cfg_wait_len(cfg_tb.wait_len), .cfg_wide(cfg_tb.wide),
    .cfg_muxed(cfg_tb.muxed), .cfg_rdy_early(cfg_tb.rdy_early),
    .cfg_rdy_hi(cfg_tb.rdy_hi), .cfg_adv_hi(cfg_tb.adv_hi),
    .cfg_strb_hi(cfg_tb.strb_hi), .cfg_ce_hi(cfg_tb.ce_hi),
    .bus_ce(bus_ce), .bus_adv(bus_adv), .bus_oe(bus_oe), .bus_we(bus_we),
    .bus_rdy(bus_rdy), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic logic lvl(input logic pol, input logic act);
    return pol ? act : !act;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic idle_check();
    chk("R10", "idle ce level", bus_ce, !cfg_tb.ce_hi);
    chk("R10", "idle adv level", bus_adv, !cfg_tb.adv_hi);
    chk("R10", "idle oe level", bus_oe, !cfg_tb.strb_hi);
    chk("R10", "idle we level", bus_we, !cfg_tb.strb_hi);
  endtask

  // One access with per-cycle comparison of every pin against a computed timeline
  task automatic access(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input logic [BE_W-1:0] b, input int r, input bit scramble);
    xbus_cfg_t c0;
    int S, M, P, A, W, H, Dk, endk, i0, capi, iend, rel, guard;
    logic [DATA_W-1:0] msk, aext;
    logic [BE_W-1:0]   bm;
    logic ce_e, adv_e, we_e, oe_e, adoe_e, act;

    @(negedge clk);
    guard = 0;
    while (!req_ready && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    idle_check();
    c0   = cfg_tb;
    S    = int'(c0.ce_setup) + 1;
    M    = c0.muxed ? int'(c0.mux_len) + 1 : 0;
    P    = S + M + 1;
    A    = (int'(c0.adv_len) + 1 < M) ? int'(c0.adv_len) + 1 : M;
    W    = int'(c0.we_len) + 1;
    H    = int'(c0.hold_len) + 1;
    i0   = imax(r, int'(c0.wait_len) + 1);
    capi = c0.rdy_early ? i0 + 1 : i0;
    iend = imax(capi, int'(c0.oe_len));
    if (wr) begin
      Dk   = P + W;
      endk = P + W + H;
    end else begin
      Dk   = P + capi + 1;
      endk = P + iend + 1 + H;
    end
    msk  = c0.wide ? {DATA_W{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
    bm   = c0.wide ? {BE_W{1'b1}} : {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}};
    aext = DATA_W'(a);

    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    req_be    = b;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;
    req_wdata = ~d;
    req_write = !wr;
    if (scramble) cfg_tb = ~c0;

    for (int k = 1; k <= endk; k++) begin
      rel       = k - P;
      act       = !wr && (k >= P) && (rel >= r);
      bus_rdy   = lvl(c0.rdy_hi, act);
      bus_ad_in = (!wr && (k >= P) && (rel >= (c0.rdy_early ? r + 1 : r))) ? d : ~d;

      ce_e   = (k > S) && (k < endk);
      adv_e  = c0.muxed && (k > S) && (k <= S + A);
      we_e   = wr && (k >= P) && (k < P + W);
      oe_e   = !wr && (k >= P) && (k <= P + iend);
      adoe_e = (c0.muxed && (k > S) && (k < P)) || (wr && (k >= P) && (k < endk));

      chk((k <= S) ? "R2" : "R7", $sformatf("ce cycle %0d", k), bus_ce, lvl(c0.ce_hi, ce_e));
      chk(c0.muxed ? "R3" : "R4", $sformatf("adv cycle %0d", k), bus_adv, lvl(c0.adv_hi, adv_e));
      chk("R5", $sformatf("we cycle %0d", k), bus_we, lvl(c0.strb_hi, we_e));
      chk("R6", $sformatf("oe cycle %0d", k), bus_oe, lvl(c0.strb_hi, oe_e));
      chk("R6", $sformatf("ad_oe cycle %0d", k), bus_ad_oe, adoe_e);
      chk("R8", $sformatf("done cycle %0d", k), rsp_done, (k == Dk));
      chk("R12", $sformatf("req_ready cycle %0d", k), req_ready, (k == endk));
      if (adoe_e && k < P) chk("R3", "muxed address on bus", bus_ad_out, aext & msk);
      if (adoe_e && k >= P) chk("R5", "write data on bus", bus_ad_out, d & msk);
      if (k == P) begin
        chk("R4", "dedicated address", bus_addr, a);
        chk("R9", "byte enables", bus_be, b & bm);
      end
      if (k == Dk && !wr) chk("R9", "read data lanes", rsp_rdata, d & msk);
      if (scramble && k == Dk) chk("R11", "done timing under changed config", rsp_done, 1'b1);
      if (k < endk) @(negedge clk);
    end
    cfg_tb  = c0;
    bus_rdy = lvl(c0.rdy_hi, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    xbus_cfg_t c;
    rst       = 1'b1;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    req_be    = '0;
    bus_rdy   = 1'b1;
    bus_ad_in = '0;
    cfg_tb    = '0;
    cfg_tb.ce_setup = 4'd4;
    cfg_tb.adv_len  = 4'd1;
    cfg_tb.mux_len  = 4'd1;
    cfg_tb.we_len   = 4'd1;
    cfg_tb.oe_len   = 8'd1;
    cfg_tb.hold_len = 4'd1;
    cfg_tb.wait_len = 8'd3;
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "req_ready after reset", req_ready, 1'b1);
    chk("R1", "done after reset", rsp_done, 1'b0);
    chk("R1", "ad_oe after reset", bus_ad_oe, 1'b0);
    chk("R1", "strobes after reset", {bus_ce, bus_adv, bus_oe, bus_we}, 4'b1111);

    // Default-length accesses in both modes
    access(1'b0, 24'h123456, 32'hA5A55A5A, 4'hF, 2, 1'b0);
    access(1'b1, 24'h00BEEF, 32'h13579BDF, 4'h3, 0, 1'b0);

    // Grid sweep across modes, widths, polarities and small lengths
    for (int idx = 0; idx < 256; idx++) begin
      c = '0;
      c.rdy_early = idx[1];
      c.muxed     = idx[2];
      c.wide      = idx[3];
      c.rdy_hi    = idx[4];
      c.adv_hi    = idx[5];
      c.strb_hi   = idx[6];
      c.ce_hi     = idx[7];
      c.ce_setup  = 4'(idx % 3);
      c.adv_len   = 4'((idx / 3) % 4);
      c.mux_len   = 4'((idx / 5) % 3);
      c.we_len    = 4'((idx / 2) % 3);
      c.oe_len    = 8'((idx / 7) % 5);
      c.hold_len  = 4'((idx / 11) % 2);
      c.wait_len  = 8'((idx / 13) % 4);
      cfg_tb = c;
      access(idx[0], 24'h5A0000 ^ ADDR_W'(idx * 32'h01357),
             32'hC3A50000 ^ (idx * 32'h9E37), 4'(idx >> 4) ^ 4'hA,
             (idx / 17) % 6, (idx % 7) == 0);
    end

    // Long fields at the top of their range (R3, R5, R7)
    c = '0;
    c.muxed = 1'b1; c.wide = 1'b1;
    c.ce_setup = 4'd15; c.adv_len = 4'd15; c.mux_len = 4'd15;
    c.we_len = 4'd15; c.hold_len = 4'd15; c.oe_len = 8'd255; c.wait_len = 8'd0;
    cfg_tb = c;
    access(1'b1, 24'hFFFFFF, 32'hFFFF0001, 4'hF, 0, 1'b0);
    access(1'b0, 24'h800001, 32'h0F0F0F0F, 4'h5, 0, 1'b1);
    // Long wait with early ready (R6)
    c = '0;
    c.rdy_early = 1'b1; c.rdy_hi = 1'b1; c.wait_len = 8'd255; c.oe_len = 8'd0;
    cfg_tb = c;
    access(1'b0, 24'h000100, 32'h89ABCDEF, 4'hF, 3, 1'b0);
    // Ready arriving late after a short wait, narrow bus (R6, R9)
    c.wait_len = 8'd0; c.rdy_early = 1'b0;
    cfg_tb = c;
    access(1'b0, 24'h7F7F7F, 32'hDEADBEEF, 4'hF, 9, 1'b1);

    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule